// File: doc/BRIEF.md
# Link Activity and Sync Detect Monitor

This block watches a serial video link from the side of a free-running reference clock. It decides whether the link clock is running, and it decides whether valid video (a toggling data-enable) is present. When the link clock stops, the block pulls the output-enable low and raises a low-power indication. When the clock comes back, the block waits through a wake-up delay before it enables the outputs again. The sync-detect flag rises only after a set number of data-enable falling edges have been seen while the link is up. It falls after a long stretch with no data-enable edge, and it falls at once when the link is lost.

Link clock activity arrives as a toggle signal: a level that flips on every link clock cycle, or on every cycle of a divided link clock. Both this toggle and the data-enable come from the link domain, and each passes through a two-flop synchroniser into the reference domain. Every delay is a parameter counted in reference-clock cycles. The defaults match a 50 MHz reference: 10 µs to detect a lost clock, 100 µs to wake, 160 ms of data-enable inactivity, and 40 falling edges to detect sync.

Top module: `link_activity_monitor`

## Requirements
- R1: During and right after synchronous reset, `out_en_o`=0, `low_power_o`=1 and `sync_det_o`=0.
- R2: From low power, the first synchronised edge of the activity toggle drops `low_power_o` on the next clock. `out_en_o` rises WAKE_CYC clocks after that, as long as activity continues.
- R3: While the link is up, if no toggle edge is seen for LOSS_CYC reference clocks, `out_en_o` falls and `low_power_o` rises.
- R4: If the activity stops during wake-up for LOSS_CYC clocks, the block returns to low power without ever enabling the outputs.
- R5: With the link up, `sync_det_o` rises on the clock that follows the EDGE_CNT-th synchronised data-enable falling edge.
- R6: After INACT_CYC reference clocks with no data-enable edge, `sync_det_o` falls and the falling-edge count restarts from zero.
- R7: Any data-enable edge, rising or falling, restarts the inactivity timer.
- R8: When the link is lost, `sync_det_o` falls on the same clock as `out_en_o` and the edge count restarts. `sync_det_o`=1 never occurs with `out_en_o`=0.
- R9: Data-enable edges seen while the link is not up are not counted toward sync detect.
- R10: Both link-domain inputs reach the decision logic through two synchroniser flops. An input change sampled on clock edge n counts as an edge in the update at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_toggle_i | input | 1 | Level that flips with link clock activity (link domain) |
| de_i | input | 1 | Video data-enable (link domain) |
| sync_det_o | output | 1 | Valid video present |
| out_en_o | output | 1 | Data/control output drivers enabled |
| low_power_o | output | 1 | Clock-loss low-power state |

## Verification
A wrong idle or wake count shows up at `out_en_o` or `low_power_o` on the exact clock where the model expects the transition, so one cycle of error is caught. A wrong edge count or a wrong inactivity timer moves the rise or fall of `sync_det_o` by at least one clock, and the per-cycle comparison reports that clock. A link-up state that is wrongly held would leave `sync_det_o` high after `out_en_o` falls, and that is visible on the very clock of the loss.

// File: rtl/lam_pkg.sv
// Shared types for the link activity monitor.
package lam_pkg;
    // Link power sequencing state
    typedef enum logic [1:0] {
        LNK_DOWN = 2'd0,
        LNK_WAKE = 2'd1,
        LNK_UP   = 2'd2
    } lnk_state_t;
endpackage

// File: rtl/lam_sync.sv
// Two-flop synchroniser with edge detection for W asynchronous bits.
// Assumes each input stays stable for at least two reference clocks.
module lam_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1, s2, s3;
        // Synchronise the bit and keep one older copy for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= d_i[b];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise_o[b] = s2 & ~s3;
        assign fall_o[b] = ~s2 & s3;
    end
endmodule

// File: rtl/lam_clk_watch.sv
// Link clock watchdog and power sequencer. It counts reference clocks since
// the last activity edge. A count that reaches LOSS_CYC means the clock is
// lost. Wake-up waits WAKE_CYC clocks of continued activity.
module lam_clk_watch
    import lam_pkg::*;
#(
    parameter int LOSS_CYC = 500,
    parameter int WAKE_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_edge_i,
    output logic up_next_o,
    output logic out_en_o,
    output logic low_power_o
);
    localparam int IW = $clog2(LOSS_CYC + 1);
    localparam int KW = $clog2(WAKE_CYC + 1);
    localparam logic [IW-1:0] LOSS_MAX = IW'(LOSS_CYC);
    localparam logic [KW-1:0] WAKE_MAX = KW'(WAKE_CYC - 1);

    logic [IW-1:0] idle_q;
    logic [KW-1:0] wake_q;
    lnk_state_t    state_q, state_d;
    logic          lost;

    assign lost = (idle_q == LOSS_MAX);

    // Count clocks since the last activity edge, saturating at the loss limit
    always_ff @(posedge clk) begin
        if (!rst_n)            idle_q <= '0;
        else if (act_edge_i)   idle_q <= '0;
        else if (!lost)        idle_q <= idle_q + 1'b1;
    end

    // Next power state from activity and wake progress
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_DOWN: if (act_edge_i) state_d = LNK_WAKE;
            LNK_WAKE: begin
                if (lost)                  state_d = LNK_DOWN;
                else if (wake_q == WAKE_MAX) state_d = LNK_UP;
            end
            LNK_UP:   if (lost) state_d = LNK_DOWN;
            default:  state_d = LNK_DOWN;
        endcase
    end

    // Register the state and run the wake-up counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LNK_DOWN;
            wake_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != LNK_WAKE) wake_q <= '0;
            else                     wake_q <= wake_q + 1'b1;
        end
    end

    assign up_next_o   = (state_d == LNK_UP);
    assign out_en_o    = (state_q == LNK_UP);
    assign low_power_o = (state_q == LNK_DOWN);

    // R2
    stay_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_DOWN && !act_edge_i) |=> state_q == LNK_DOWN);
    // R3
    up_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_UP) |=> (state_q == LNK_UP || state_q == LNK_DOWN));
    // R4
    wake_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_WAKE) |-> (wake_q <= WAKE_MAX));
endmodule

// File: rtl/lam_sync_det.sv
// Sync detector. It counts data-enable falling edges while the link is up
// and raises the flag at EDGE_CNT. The flag is cleared after INACT_CYC clocks
// without any data-enable edge, or when the link leaves the up state.
module lam_sync_det #(
    parameter int EDGE_CNT  = 40,
    parameter int INACT_CYC = 8000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic de_rise_i,
    input  logic de_fall_i,
    input  logic up_next_i,
    output logic sync_o
);
    localparam int NW = $clog2(INACT_CYC + 1);
    localparam int EW = $clog2(EDGE_CNT + 1);
    localparam logic [NW-1:0] INACT_MAX = NW'(INACT_CYC);
    localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_CNT - 1);

    logic [NW-1:0] inact_q;
    logic [EW-1:0] edges_q;
    logic          sync_q;
    logic          idle_out;

    assign idle_out = (inact_q == INACT_MAX);

    // Time since the most recent data-enable edge of either polarity
    always_ff @(posedge clk) begin
        if (!rst_n)                       inact_q <= '0;
        else if (de_rise_i || de_fall_i)  inact_q <= '0;
        else if (!idle_out)               inact_q <= inact_q + 1'b1;
    end

    // Count falling edges and set or clear the flag
    always_ff @(posedge clk) begin
        if (!rst_n || !up_next_i || idle_out) begin
            edges_q <= '0;
            sync_q  <= 1'b0;
        end else if (de_fall_i) begin
            if (edges_q == EDGE_LAST) sync_q  <= 1'b1;
            else                      edges_q <= edges_q + 1'b1;
        end
    end

    assign sync_o = sync_q;

    // R5
    rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> $past(de_fall_i));
    // R6
    inact_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_out |=> !sync_q);
endmodule

// File: rtl/link_activity_monitor.sv
// Top level: synchronises the link activity toggle and data-enable into the
// reference domain, then drives the power sequencer and the sync detector.
module link_activity_monitor #(
    parameter int LOSS_CYC  = 500,
    parameter int WAKE_CYC  = 5000,
    parameter int INACT_CYC = 8000000,
    parameter int EDGE_CNT  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_toggle_i,
    input  logic de_i,
    output logic sync_det_o,
    output logic out_en_o,
    output logic low_power_o
);
    logic [1:0] rise, fall;
    logic       up_next;

    lam_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({de_i, lnk_toggle_i}),
        .rise_o(rise), .fall_o(fall)
    );

    lam_clk_watch #(.LOSS_CYC(LOSS_CYC), .WAKE_CYC(WAKE_CYC)) u_watch (
        .clk(clk), .rst_n(rst_n),
        .act_edge_i(rise[0] | fall[0]),
        .up_next_o(up_next), .out_en_o(out_en_o), .low_power_o(low_power_o)
    );

    lam_sync_det #(.EDGE_CNT(EDGE_CNT), .INACT_CYC(INACT_CYC)) u_det (
        .clk(clk), .rst_n(rst_n),
        .de_rise_i(rise[1]), .de_fall_i(fall[1]),
        .up_next_i(up_next), .sync_o(sync_det_o)
    );

    // R8
    sync_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_det_o |-> out_en_o);
endmodule

// File: tb/link_activity_monitor_tb.sv
module link_activity_monitor_tb;
    localparam int L = 8, W = 20, I = 60, E = 5;

    logic clk = 1'b0, rst_n = 1'b0, tg = 1'b0, de = 1'b0;
    logic sync_det, out_en, low_pw;
    always #10 clk = ~clk;

    link_activity_monitor #(.LOSS_CYC(L), .WAKE_CYC(W), .INACT_CYC(I), .EDGE_CNT(E)) u_dut (
        .clk(clk), .rst_n(rst_n), .lnk_toggle_i(tg), .de_i(de),
        .sync_det_o(sync_det), .out_en_o(out_en), .low_power_o(low_pw));

    int checks = 0, fails = 0, cyc = 0;
    string phase = "R1";
    bit link_run = 0, de_run = 0;
    int lk_div = 0, de_div = 0;

    // Behavioural reference: input history and integer timers
    int tq[$], dq[$];
    int m_st = 0, m_idle = 0, m_wk = 0, m_in = 0, m_ec = 0, m_sync = 0;

    task automatic chk(string req, int got, int exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Link-side stimulus generators, driven away from the active edge
    always @(negedge clk) begin
        if (link_run) begin
            lk_div++;
            if (lk_div >= 2) begin lk_div = 0; tg = ~tg; end
        end
        if (de_run) begin
            de_div++;
            if (de_div >= 3) begin de_div = 0; de = ~de; end
        end
    end

    // Reference model update on every active edge
    always @(posedge clk) begin
        int te, df, dr, n_st, n_idle, n_in;
        cyc++;
        if (!rst_n) begin
            tq = '{0, 0, 0, 0}; dq = '{0, 0, 0, 0};
            m_st = 0; m_idle = 0; m_wk = 0; m_in = 0; m_ec = 0; m_sync = 0;
        end else begin
            tq.push_front(int'(tg)); dq.push_front(int'(de));
            void'(tq.pop_back()); void'(dq.pop_back());
            te = (tq[2] != tq[3]);       // R10 two-clock latency
            df = (dq[3] == 1 && dq[2] == 0);
            dr = (dq[3] == 0 && dq[2] == 1);
            n_idle = te ? 0 : (m_idle < L ? m_idle + 1 : m_idle);
            n_st = m_st;
            if (m_st == 0 && te) n_st = 1;
            else if (m_st == 1) n_st = (m_idle == L) ? 0 : (m_wk == W - 1 ? 2 : 1);
            else if (m_st == 2 && m_idle == L) n_st = 0;
            m_wk = (m_st == 1) ? m_wk + 1 : 0;
            n_in = (df || dr) ? 0 : (m_in < I ? m_in + 1 : m_in);
            if (n_st != 2 || m_in == I) begin m_ec = 0; m_sync = 0; end
            else if (df) begin
                if (m_ec == E - 1) m_sync = 1; else m_ec++;
            end
            m_st = n_st; m_idle = n_idle; m_in = n_in;
        end
    end

    // Per-cycle comparison against the model, plus watchdog
    always @(negedge clk) begin
        chk(phase, int'(out_en), int'(m_st == 2), "out_en_o");
        chk(phase, int'(low_pw), int'(m_st == 0), "low_power_o");
        chk(phase, int'(sync_det), m_sync, "sync_det_o");
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(out_en), 0, "reset out_en_o");
        chk("R1", int'(low_pw), 1, "reset low_power_o");
        chk("R1", int'(sync_det), 0, "reset sync_det_o");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", int'(low_pw), 1, "idle after reset");

        // R4 and R9: short burst of activity, DE toggling during wake
        phase = "R4"; link_run = 1; de_run = 1;
        repeat (8) @(negedge clk);
        chk("R2", int'(low_pw), 0, "wake started");
        link_run = 0;
        repeat (W + L + 6) @(negedge clk);
        chk("R4", int'(out_en), 0, "aborted wake out_en_o");
        chk("R4", int'(low_pw), 1, "aborted wake low_power_o");
        chk("R9", int'(sync_det), 0, "no counting while down");
        de_run = 0;

        // R2: full wake-up
        phase = "R2"; link_run = 1;
        repeat (W + 8) @(negedge clk);
        chk("R2", int'(out_en), 1, "woke up");

        // R5: falling edges raise sync detect
        phase = "R5"; de_run = 1;
        repeat (6 * E + 8) @(negedge clk);
        chk("R5", int'(sync_det), 1, "sync after edge count");

        // R7: DE held high shorter than the timeout keeps sync
        phase = "R7"; wait (de == 1'b1); de_run = 0;
        repeat (I - 15) @(negedge clk);
        chk("R7", int'(sync_det), 1, "held during short pause");
        de = 1'b0;
        repeat (I - 15) @(negedge clk);
        chk("R7", int'(sync_det), 1, "edge restarted timer");

        // R6: long inactivity clears sync; restart needs full count
        phase = "R6";
        repeat (I + 10) @(negedge clk);
        chk("R6", int'(sync_det), 0, "inactivity timeout");
        de_run = 1;
        repeat (6 * (E - 1)) @(negedge clk);
        chk("R6", int'(sync_det), 0, "count restarted");
        repeat (20) @(negedge clk);
        chk("R6", int'(sync_det), 1, "sync re-acquired");

        // R8 and R3: clock loss drops sync with out_en
        phase = "R8"; link_run = 0;
        repeat (L + 8) @(negedge clk);
        chk("R3", int'(out_en), 0, "loss out_en_o");
        chk("R3", int'(low_pw), 1, "loss low_power_o");
        chk("R8", int'(sync_det), 0, "loss sync_det_o");

        // R8: after return, edge count starts from zero
        phase = "R8"; link_run = 1;
        repeat (W + 6) @(negedge clk);
        chk("R8", int'(sync_det), 0, "no sync right after wake");
        repeat (40) @(negedge clk);
        chk("R8", int'(sync_det), 1, "sync after fresh count");
        finish_run();
    end
endmodule